// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block runs the device side of one receive queue whose buffers are described by a power-of-two ring of descriptors kept in host memory. The host hands over empty buffers by advancing a write index. The block walks the ring with its own fetch index and opens the buffer at that index when a frame starts. It closes the buffer when the frame ends, or when an inactivity timer runs out first. On each close it publishes the index of the buffer it just filled through a status write-back strobe and can raise a one-cycle interrupt.

A 16-bit configuration word sets the following. The channel mode goes from off, to drain (stop at the end of the current frame), to run. It also sets the ring size exponent, the interrupt destination and the timeout in units of 32 microsecond ticks. When the channel has stopped, an idle flag tells software it is safe to reconfigure. The block does not fetch descriptors and does not move data.

Configuration layout: bits [1:0] mode (00 off, 01 drain, 10 run, 11 treated as off). Bits [5:2] ring size exponent. Bits [7:6] interrupt destination (00 none, 01 host). Bits [15:8] timeout.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset, fetch_idx_o and stat_idx_o are 0, stat_we_o and irq_o are 0, and idle_o is 1.
- R2: The ring holds 2^E entries, where E is the exponent in cfg bits [5:2], clamped to the range 5..12. The fetch index counts up by one per filled buffer and wraps to 0 after 2^E-1.
- R3: The host write index is reduced to the ring size and its low three bits are cleared before use. Buffers are available while the fetch index differs from this reduced value.
- R4: When the fetch index equals the reduced host index, a frame start is ignored. The fetch index does not move and no status is written.
- R5: A frame end while a buffer is open closes that buffer. On the next cycle stat_we_o pulses for one cycle, stat_idx_o holds the filled index, and fetch_idx_o has advanced by one. While the buffer stays open, the fetch index holds.
- R6: With a timeout T other than 0 (cfg bits [15:8]), an open buffer is closed exactly as in R5 once 32*T microsecond ticks have been seen since it opened. It is not closed after 32*T-1 ticks. T = 0 disables the timer.
- R7: irq_o pulses together with stat_we_o only when the interrupt destination is 01. With destination 00, no interrupt is raised.
- R8: Mode 00 stops the channel at once. An open buffer is abandoned without a status write, and idle_o is 1 from the next cycle.
- R9: Mode 01 accepts no new frames. A buffer already open still completes normally, and idle_o rises in the cycle the buffer closes, or at once if none is open.
- R10: In mode 10, frame starts are accepted and idle_o is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 16 | Configuration word (mode, size exponent, interrupt destination, timeout) |
| host_widx_i | input | 12 | Host write index |
| frm_start_i | input | 1 | A frame begins writing into the current buffer |
| frm_end_i | input | 1 | The frame in progress has ended |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| fetch_idx_o | output | 12 | Index of the next descriptor to use |
| stat_idx_o | output | 12 | Index of the most recently filled descriptor |
| stat_we_o | output | 1 | Status write-back strobe, one cycle per closed buffer |
| irq_o | output | 1 | Host interrupt pulse |
| idle_o | output | 1 | Channel stopped |

## Verification
The bench goes after the ring edges. It checks a write index whose low bits are set, which a design without the rounding would treat as extra buffers. It checks out-of-range size exponents, which must clamp. It checks a write index equal to the fetch index, which must not be counted as a full ring. It checks the wrap from the last slot to slot 0, where a wrong mask would run past the ring. The timer is probed one tick before and at its limit, so an off-by-one close shows up. The two stop modes are driven with a buffer open: an immediate stop that still wrote status, or a drain that dropped the open frame or took a new one, is caught at the ports.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int IDX_W      = 12;
  localparam int LOG_MIN    = 5;
  localparam int LOG_MAX    = 12;
  localparam int TMO_W      = 8;
  localparam int UNIT_TICKS = 32;

  typedef enum logic [1:0] {
    CH_OFF   = 2'b00,
    CH_DRAIN = 2'b01,
    CH_RUN   = 2'b10,
    CH_RSVD  = 2'b11
  } ch_mode_e;

  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic [1:0]       dest;
    logic [3:0]       lsz;
    logic [1:0]       mode;
  } cfg_t;

  // clamp the size exponent into its legal range
  function automatic logic [3:0] clamp_log(input logic [3:0] lsz);
    if (int'(lsz) < LOG_MIN) return 4'(LOG_MIN);
    if (int'(lsz) > LOG_MAX) return 4'(LOG_MAX);
    return lsz;
  endfunction

  // mask covering 2^lsz entries (wraps cleanly when lsz == IDX_W)
  function automatic logic [IDX_W-1:0] ring_mask(input logic [3:0] lsz);
    logic [IDX_W-1:0] one;
    one = 1;
    return (one << clamp_log(lsz)) - one;
  endfunction

  // host index reduced to ring size and rounded down to a multiple of 8
  function automatic logic [IDX_W-1:0] host_eff(input logic [IDX_W-1:0] widx,
                                                input logic [IDX_W-1:0] mask);
    return widx & mask & ~IDX_W'(7);
  endfunction
endpackage

// File: rtl/rxr_idx.sv
module rxr_idx
  import rxr_pkg::*;
#(
  parameter int W = IDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] host_widx_i,
  input  logic         adv_i,
  output logic [W-1:0] fetch_o,
  output logic         avail_o,
  output logic [W-1:0] stat_idx_o,
  output logic         stat_we_o
);
  logic [W-1:0] ridx_q;
  logic [W-1:0] ridx_m;
  logic [W-1:0] weff;

  assign ridx_m  = ridx_q & mask_i;
  assign weff    = host_eff(host_widx_i, mask_i);
  assign avail_o = (ridx_m != weff);
  assign fetch_o = ridx_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q     <= '0;
      stat_idx_o <= '0;
      stat_we_o  <= 1'b0;
    end else begin
      stat_we_o <= adv_i;
      if (adv_i) begin
        ridx_q     <= (ridx_m + W'(1)) & mask_i;
        stat_idx_o <= ridx_m;
      end
    end
  end

  // status write-back carries the index that was current before the close
  p_stat_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we_o |-> stat_idx_o == $past(ridx_m));
endmodule

// File: rtl/rxr_tmr.sv
module rxr_tmr
  import rxr_pkg::*;
#(
  parameter int TW    = TMO_W,
  parameter int UNIT  = UNIT_TICKS,
  localparam int PW   = $clog2(UNIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic          tick_i,
  input  logic [TW-1:0] tmo_i,
  output logic          hit_o
);
  logic [PW-1:0] pre_q;
  logic [TW-1:0] units_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (!open_i) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (tick_i) begin
      if (pre_q == PW'(UNIT - 1)) begin
        pre_q <= '0;
        if (units_q != tmo_i) units_q <= units_q + TW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  assign hit_o = open_i && (tmo_i != '0) && (units_q == tmo_i);

  // no count survives a closed buffer
  p_tmr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> (units_q == '0));
endmodule

// File: rtl/rxr_chan.sv
module rxr_chan
  import rxr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       frm_start_i,
  input  logic       frm_end_i,
  input  logic       avail_i,
  input  logic       tmo_hit_i,
  output logic       open_o,
  output logic       close_o,
  output logic       idle_o
);
  logic run, drain, stop;
  logic accept, open_d;

  assign run   = (mode_i == CH_RUN);
  assign drain = (mode_i == CH_DRAIN);
  assign stop  = !run && !drain;

  assign accept  = run && avail_i && !open_o && frm_start_i;
  assign close_o = open_o && !stop && (frm_end_i || tmo_hit_i);

  always_comb begin
    open_d = open_o;
    if (stop)         open_d = 1'b0;
    else if (accept)  open_d = 1'b1;
    else if (close_o) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      idle_o <= 1'b1;
    end else begin
      open_o <= open_d;
      idle_o <= stop || (drain && !open_d);
    end
  end

  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CH_OFF) |=> idle_o);
  p_run_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CH_RUN) |=> !idle_o);
  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !open_o) |=> !open_o);
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int W    = IDX_W,
  parameter int TW   = TMO_W,
  parameter int UNIT = UNIT_TICKS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  cfg_i,
  input  logic [W-1:0] host_widx_i,
  input  logic         frm_start_i,
  input  logic         frm_end_i,
  input  logic         us_tick_i,
  output logic [W-1:0] fetch_idx_o,
  output logic [W-1:0] stat_idx_o,
  output logic         stat_we_o,
  output logic         irq_o,
  output logic         idle_o
);
  cfg_t         cfg;
  logic [W-1:0] mask;
  logic         avail, open_q, close, tmo_hit;
  logic         irq_q;

  assign cfg  = cfg_t'(cfg_i);
  assign mask = W'(ring_mask(cfg.lsz));

  rxr_chan u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (cfg.mode),
    .frm_start_i(frm_start_i),
    .frm_end_i  (frm_end_i),
    .avail_i    (avail),
    .tmo_hit_i  (tmo_hit),
    .open_o     (open_q),
    .close_o    (close),
    .idle_o     (idle_o)
  );

  rxr_idx #(.W(W)) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_i     (mask),
    .host_widx_i(host_widx_i),
    .adv_i      (close),
    .fetch_o    (fetch_idx_o),
    .avail_o    (avail),
    .stat_idx_o (stat_idx_o),
    .stat_we_o  (stat_we_o)
  );

  rxr_tmr #(.TW(TW), .UNIT(UNIT)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .open_i(open_q),
    .tick_i(us_tick_i),
    .tmo_i (cfg.tmo),
    .hit_o (tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= close && (cfg.dest == 2'b01);
  end
  assign irq_o = irq_q;

  p_irq_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_we_o);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !close && $stable(cfg_i)) |=> (fetch_idx_o == $past(fetch_idx_o)) || !$stable(cfg_i));
endmodule

// File: tb/sim_rx_ring_ctrl.sv
module sim_rx_ring_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cfg = '0;
  logic [11:0] widx = '0;
  logic        fs = 0, fe = 0, tick = 0;
  logic [11:0] fetch, sidx;
  logic        swe, irq, idle;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_ring_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .host_widx_i(widx),
    .frm_start_i(fs), .frm_end_i(fe), .us_tick_i(tick),
    .fetch_idx_o(fetch), .stat_idx_o(sidx), .stat_we_o(swe),
    .irq_o(irq), .idle_o(idle)
  );

  function automatic logic [15:0] mk(input logic [1:0] m, input logic [3:0] l,
                                     input logic [1:0] d, input logic [7:0] t);
    return {t, d, l, m};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    fs = 0; fe = 0; tick = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // start then end a frame; returns strobe seen after close edge
  task automatic frame(output bit we);
    fs = 1;
    @(negedge clk);
    fs = 0; fe = 1;
    @(negedge clk);
    fe = 0;
    we = swe;
  endtask

  // {size exponent, host index, frames tried, expected fetch index}
  localparam logic [31:0] VEC [6] = '{
    {4'd5,  12'd8,   8'd10, 8'd8},
    {4'd5,  12'd13,  8'd10, 8'd8},
    {4'd5,  12'd40,  8'd10, 8'd8},
    {4'd8,  12'd16,  8'd5,  8'd5},
    {4'd4,  12'd32,  8'd3,  8'd0},
    {4'd13, 12'd0,   8'd3,  8'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit we;
    int f0;
    @(negedge clk);
    // R1 reset state
    chk(fetch == 0, "R1 fetch", fetch, 0);
    chk(sidx == 0, "R1 stat", sidx, 0);
    chk(swe == 0 && irq == 0, "R1 strobes", {swe, irq}, 0);
    chk(idle == 1, "R1 idle", idle, 1);
    do_reset();

    // table: R2 clamp, R3 rounding, R4 equal indices
    foreach (VEC[i]) begin
      do_reset();
      cfg  = mk(2'b10, VEC[i][31:28], 2'b01, 8'd0);
      widx = VEC[i][27:16];
      for (int k = 0; k < int'(VEC[i][15:8]); k++) frame(we);
      chk(fetch == 12'(VEC[i][7:0]), "R3 R4 fetch after frames", fetch, VEC[i][7:0]);
      if (VEC[i][7:0] != 0)
        chk(sidx == 12'(VEC[i][7:0] - 1), "R5 stat idx", sidx, VEC[i][7:0] - 1);
      else
        chk(sidx == 0, "R4 no status", sidx, 0);
    end

    // R10 run mode is busy
    chk(idle == 0, "R10 idle in run", idle, 0);

    // R2 wrap with 32 entries
    do_reset();
    cfg = mk(2'b10, 4'd5, 2'b01, 8'd0);
    widx = 12'd24;
    for (int k = 0; k < 24; k++) frame(we);
    chk(fetch == 24, "R2 fill", fetch, 24);
    widx = 12'd0;
    for (int k = 0; k < 8; k++) frame(we);
    chk(fetch == 0, "R2 wrap fetch", fetch, 0);
    chk(sidx == 31, "R2 wrap stat", sidx, 31);
    frame(we);
    chk(we == 0, "R4 full ignored", we, 0);

    // R5/R7 single frame strobe and irq
    do_reset();
    cfg = mk(2'b10, 4'd5, 2'b01, 8'd0);
    widx = 12'd8;
    frame(we);
    chk(we == 1 && irq == 1, "R7 irq with status", {we, irq}, 3);
    @(negedge clk);
    chk(swe == 0 && irq == 0, "R5 one-cycle strobe", {swe, irq}, 0);

    // R6 timeout T=2 -> 64 ticks
    do_reset();
    cfg = mk(2'b10, 4'd5, 2'b01, 8'd2);
    widx = 12'd8;
    fs = 1; @(negedge clk); fs = 0;
    tick = 1;
    repeat (63) @(negedge clk);
    tick = 0;
    @(negedge clk);
    chk(fetch == 0 && swe == 0, "R6 not before limit", fetch, 0);
    tick = 1; @(negedge clk); tick = 0;
    @(negedge clk);
    chk(swe == 1 && fetch == 1 && sidx == 0, "R6 closes at limit", fetch, 1);

    // R6 T=0 never times out; R7 no irq with dest 00
    cfg = mk(2'b10, 4'd5, 2'b00, 8'd0);
    fs = 1; @(negedge clk); fs = 0;
    tick = 1; repeat (200) @(negedge clk); tick = 0;
    chk(fetch == 1, "R6 disabled timer", fetch, 1);
    fe = 1; @(negedge clk); fe = 0;
    chk(swe == 1 && irq == 0, "R7 no irq dest 00", {swe, irq}, 2);

    // R8 immediate stop abandons open buffer
    do_reset();
    cfg = mk(2'b10, 4'd5, 2'b01, 8'd0);
    widx = 12'd8;
    fs = 1; @(negedge clk); fs = 0;
    cfg = mk(2'b00, 4'd5, 2'b01, 8'd0);
    @(negedge clk);
    chk(idle == 1, "R8 idle after off", idle, 1);
    fe = 1; @(negedge clk); fe = 0;
    chk(swe == 0 && fetch == 0, "R8 no close after off", fetch, 0);

    // R9 drain completes open frame then idles
    cfg = mk(2'b10, 4'd5, 2'b01, 8'd0);
    @(negedge clk);
    f0 = fetch;
    fs = 1; @(negedge clk); fs = 0;
    cfg = mk(2'b01, 4'd5, 2'b01, 8'd0);
    @(negedge clk);
    chk(idle == 0, "R9 busy while open", idle, 0);
    fe = 1; @(negedge clk); fe = 0;
    chk(swe == 1 && idle == 1, "R9 close then idle", {swe, idle}, 3);
    frame(we);
    chk(we == 0 && fetch == 12'(f0 + 1), "R9 no new frame", fetch, f0 + 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule